// File: doc/BRIEF.md
# Chained Countdown Timer Bank with Watchdog Reset

This block holds a bank of countdown timers, each 64 bits wide, behind a small register port that is 32 bits wide. Every timer has its own control word, which holds an enable bit, a mode, a trigger-source code and a prescaler, and a reload value that software writes as two 32-bit halves. A timer counts down to zero, one step every prescaler period, and then emits a single-cycle end-count pulse.

A timer in retrigger mode does not start on its own. It waits for the end-count pulse of the timer below it, and each such pulse reloads the timer and restarts it. Software therefore keeps a watchdog alive without ever disabling it: the watchdog runs in retrigger mode on timer 1, and a one-shot timer 0 is loaded with zero. To kick the watchdog, software disables and then re-enables timer 0. That produces an immediate end-count on timer 0, which reloads timer 1.

A select register marks which timers drive the watchdog. When a selected timer reaches end-count, the block raises a reset request for a fixed number of cycles. Reading the low count word captures the high word of the same timer, so a 64-bit value can be read across two accesses without tearing.

Top module: `chain_timer_bank`

## Requirements
- R1: After reset:
  - the control words of timers 0 and 1 read 0x0000_0200, and those of timers 2 and 3 read 0x0000_0201 (enabled, prescaler 2);
  - the watchdog select register at 0x40 reads 0;
  - `rst_req_o` is low.
- R2: The control word of timer n is at n*0x10. Its fields are:
  - bit 0: enable;
  - bit 1: active, read-only, set while the timer is enabled and counting;
  - bits [3:2]: mode, where 3 is retrigger and any other value is one-shot;
  - bits [7:4]: trigger source;
  - bits [15:8]: prescaler.
  Writes to bit 1 and to bits [31:16] have no effect, and those bits read 0.
- R3: A one-shot timer enabled with count N and an effective prescaler P pulses `end_count_o[n]` high in the (N*P+1)th cycle after the edge that writes the enable. The count word reads 0 afterwards, and the active bit clears.
- R4: A prescaler field of 0 or 1 gives the same timing as a prescaler of 2.
- R5: Enabling a one-shot timer whose count is 0 produces its end-count pulse in the first cycle after the enable edge.
- R6: Retrigger mode with trigger source 5:
  - The timer reloads its reload value one cycle after the end-count pulse of timer n-1 (timer 0 takes timer 3), then counts down as in R3.
  - Enabling the timer in this mode does not start it.
  - With any other trigger source code, the neighbour's pulse is ignored.
- R7: Reading the low count word (control+0x4) captures the timer's high count half. A later read of the high word (control+0x8) returns that captured value, even if the count has changed since.
- R8: Watchdog select register at 0x40, bit n for timer n:
  - A timer's end-count pulse with its select bit set drives `rst_req_o` high one cycle after the pulse, for PULSE_LEN (16) cycles.
  - End-count pulses of unselected timers are ignored.
- R9: The end-count pulse lasts one cycle. A timer that is disabled while counting stops and produces no pulse.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| end_count_o | output | 4 | Per-timer end-count pulse |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
Register reads complete one cycle after the strobe. The bench's driver queues the expected word when it raises the strobe, and the monitor compares the word shortly after the following clock edge.

End-count timing is measured in whole cycles from the clock edge that wrote the enable or the kick. The bench expects a one-shot pulse after N*P+1 cycles and a chained pulse after R*P+3 cycles. It expects the reset request one cycle after that chained pulse, and it samples one time unit after each edge so that every count is exact.

Cases that must produce nothing are watched every cycle for a fixed window. These are: a timer disabled mid-count, a wrong trigger code, a deselected watchdog, and kicks that arrive in time.

// File: rtl/ctb_pkg.sv
// Package: shared constants and the control-word layout of the timer bank.
// Assumes: control fields occupy bits [15:0]; the upper half reads as zero.
package ctb_pkg;

    localparam logic [1:0] MODE_ONESHOT = 2'b00;
    localparam logic [1:0] MODE_RETRIG  = 2'b11;
    localparam logic [3:0] TRIG_PREV    = 4'd5;
    localparam logic [7:0] PRESC_MIN    = 8'd2;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_LO   = 4'h4;
    localparam logic [3:0] OFS_HI   = 4'h8;

    typedef struct packed {
        logic [7:0] presc;
        logic [3:0] trig;
        logic [1:0] mode;
        logic       active;
        logic       en;
    } ctb_ctrl_t;

endpackage

// File: rtl/ctb_timer.sv
// Module: one countdown timer with prescaler, one-shot and retrigger modes.
// Assumes: CNT_W is between 33 and 64; trig_in is a one-cycle pulse from the
// neighbouring timer; count writes update both the reload and live count.
module ctb_timer
    import ctb_pkg::*;
#(
    parameter int   CNT_W  = 64,
    parameter logic RST_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [31:0]      wdata,
    input  logic             trig_in,
    output ctb_ctrl_t        ctrl_rd,
    output logic [CNT_W-1:0] count_o,
    output logic             en_o,
    output logic             evt_o
);
    localparam int HI_W = CNT_W - 32;

    logic             en_q;
    logic [1:0]       mode_q;
    logic [3:0]       trig_q;
    logic [7:0]       presc_q;
    logic             done_q;
    logic [7:0]       pc_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic             evt_q;

    logic [7:0] presc_eff;
    logic       active;
    logic       tick;
    logic       trig_hit;

    // Derive the effective prescaler, the tick and the trigger condition.
    always_comb begin
        presc_eff = (presc_q < PRESC_MIN) ? PRESC_MIN : presc_q;
        active    = en_q & ~done_q;
        tick      = (pc_q == presc_eff - 8'd1);
        trig_hit  = en_q & (mode_q == MODE_RETRIG) & (trig_q == TRIG_PREV) & trig_in;
    end

    // Control fields, countdown, retrigger reload and count-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= RST_EN;
            mode_q   <= MODE_ONESHOT;
            trig_q   <= 4'd0;
            presc_q  <= PRESC_MIN;
            done_q   <= 1'b0;
            pc_q     <= 8'd0;
            count_q  <= '0;
            reload_q <= '0;
            evt_q    <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (ctrl_we) begin
                en_q    <= wdata[0];
                mode_q  <= wdata[3:2];
                trig_q  <= wdata[7:4];
                presc_q <= wdata[15:8];
                if (wdata[0] && !en_q) begin
                    done_q <= (wdata[3:2] == MODE_RETRIG);
                    pc_q   <= 8'd0;
                end
            end else if (trig_hit) begin
                count_q <= reload_q;
                done_q  <= 1'b0;
                pc_q    <= 8'd0;
            end else if (active) begin
                if (count_q == '0) begin
                    evt_q  <= 1'b1;
                    done_q <= 1'b1;
                end else if (tick) begin
                    count_q <= count_q - 1'b1;
                    pc_q    <= 8'd0;
                end else begin
                    pc_q <= pc_q + 8'd1;
                end
            end
            if (lo_we) begin
                reload_q[31:0] <= wdata;
                count_q[31:0]  <= wdata;
            end
            if (hi_we) begin
                reload_q[CNT_W-1:32] <= wdata[HI_W-1:0];
                count_q[CNT_W-1:32]  <= wdata[HI_W-1:0];
            end
        end
    end

    // Present the control word, the live count and the pulse.
    always_comb begin
        ctrl_rd.presc  = presc_q;
        ctrl_rd.trig   = trig_q;
        ctrl_rd.mode   = mode_q;
        ctrl_rd.active = active;
        ctrl_rd.en     = en_q;
        count_o        = count_q;
        en_o           = en_q;
        evt_o          = evt_q;
    end

endmodule

// File: rtl/ctb_regif.sv
// Module: register decode, registered read mux and per-timer high-word capture.
// Assumes: NUM >= 2; timer n occupies 16 bytes at n*0x10; select register follows.
module ctb_regif
    import ctb_pkg::*;
#(
    parameter int NUM    = 4,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  ctb_ctrl_t [NUM-1:0]       ctrl_rd,
    input  logic [NUM-1:0][CNT_W-1:0] count_in,
    input  logic [NUM-1:0]            sel_rd,
    output logic [NUM-1:0]            ctrl_we,
    output logic [NUM-1:0]            lo_we,
    output logic [NUM-1:0]            hi_we,
    output logic                      sel_we,
    output logic [31:0]               rdata
);
    localparam int IDX_W   = $clog2(NUM);
    localparam int HI_W    = CNT_W - 32;
    localparam int SEL_ADR = NUM * 16;

    logic [ADDR_W-5:0]     blk;
    logic [3:0]            word;
    logic                  in_tmr;
    logic                  sel_hit;
    logic [IDX_W-1:0]      idx;
    logic [31:0]           rd_nxt;
    logic [NUM-1:0][HI_W-1:0] hi_lat;
    logic [31:0]           rdata_q;

    // Split the address into timer block and word offset.
    always_comb begin
        blk     = bus_addr[ADDR_W-1:4];
        word    = bus_addr[3:0];
        in_tmr  = (int'(blk) < NUM);
        idx     = blk[IDX_W-1:0];
        sel_hit = (bus_addr == ADDR_W'(SEL_ADR));
    end

    // Decode the write strobes per timer and for the select register.
    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            ctrl_we[i] = bus_wr & in_tmr & (idx == IDX_W'(i)) & (word == OFS_CTRL);
            lo_we[i]   = bus_wr & in_tmr & (idx == IDX_W'(i)) & (word == OFS_LO);
            hi_we[i]   = bus_wr & in_tmr & (idx == IDX_W'(i)) & (word == OFS_HI);
        end
        sel_we = bus_wr & sel_hit;
    end

    // Select the next read word.
    always_comb begin
        rd_nxt = 32'd0;
        if (in_tmr) begin
            case (word)
                OFS_CTRL: rd_nxt = 32'(ctrl_rd[idx]);
                OFS_LO:   rd_nxt = count_in[idx][31:0];
                OFS_HI:   rd_nxt = 32'(hi_lat[idx]);
                default:  rd_nxt = 32'd0;
            endcase
        end else if (sel_hit) begin
            rd_nxt = 32'(sel_rd);
        end
    end

    // Capture the high half whenever the low half of a timer is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_lat <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (bus_rd && in_tmr && (idx == IDX_W'(i)) && (word == OFS_LO))
                    hi_lat[i] <= count_in[i][CNT_W-1:32];
            end
        end
    end

    // Register the read data, holding it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= 32'd0;
        else if (bus_rd)
            rdata_q <= rd_nxt;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ctb_wdog.sv
// Module: watchdog source select and fixed-length reset request stretcher.
// Assumes: evt_in carries one-cycle end-count pulses from enabled timers only.
module ctb_wdog #(
    parameter int NUM       = 4,
    parameter int PULSE_LEN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_we,
    input  logic [NUM-1:0] sel_wdata,
    input  logic [NUM-1:0] evt_in,
    output logic [NUM-1:0] sel_o,
    output logic           rst_req_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [NUM-1:0] sel_q;
    logic [CW-1:0]  cnt_q;
    logic           hit;

    // Detect an end-count from any selected timer.
    always_comb hit = |(evt_in & sel_q);

    // Hold the select mask and stretch the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (sel_we)
                sel_q <= sel_wdata;
            if (hit)
                cnt_q <= CW'(PULSE_LEN);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign sel_o     = sel_q;
    assign rst_req_o = (cnt_q != '0);

endmodule

// File: rtl/chain_timer_bank.sv
// Module: top of the chained timer bank; timer n may retrigger from timer n-1.
// Assumes: single clock, synchronous active-low reset, one access per strobe.
module chain_timer_bank
    import ctb_pkg::*;
#(
    parameter int             NUM         = 4,
    parameter int             CNT_W       = 64,
    parameter int             ADDR_W      = 8,
    parameter int             PULSE_LEN   = 16,
    parameter logic [NUM-1:0] RST_EN_MASK = NUM'(4'b1100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [NUM-1:0]   end_count_o,
    output logic             rst_req_o
);
    ctb_ctrl_t [NUM-1:0]       ctrl_rd;
    logic [NUM-1:0][CNT_W-1:0] count;
    logic [NUM-1:0]            ctrl_we;
    logic [NUM-1:0]            lo_we;
    logic [NUM-1:0]            hi_we;
    logic                      sel_we;
    logic [NUM-1:0]            wd_sel;
    logic [NUM-1:0]            tmr_en;
    logic [NUM-1:0]            evt;

    ctb_regif #(
        .NUM    (NUM),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .ctrl_rd  (ctrl_rd),
        .count_in (count),
        .sel_rd   (wd_sel),
        .ctrl_we  (ctrl_we),
        .lo_we    (lo_we),
        .hi_we    (hi_we),
        .sel_we   (sel_we),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < NUM; i++) begin : g_tmr
        localparam int PREV = (i + NUM - 1) % NUM;
        ctb_timer #(
            .CNT_W  (CNT_W),
            .RST_EN (RST_EN_MASK[i])
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[i]),
            .lo_we   (lo_we[i]),
            .hi_we   (hi_we[i]),
            .wdata   (bus_wdata),
            .trig_in (evt[PREV]),
            .ctrl_rd (ctrl_rd[i]),
            .count_o (count[i]),
            .en_o    (tmr_en[i]),
            .evt_o   (evt[i])
        );
    end

    ctb_wdog #(
        .NUM       (NUM),
        .PULSE_LEN (PULSE_LEN)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_wdata (bus_wdata[NUM-1:0]),
        .evt_in    (evt),
        .sel_o     (wd_sel),
        .rst_req_o (rst_req_o)
    );

    assign end_count_o = evt;

endmodule

// File: rtl/ctb_checker.sv
// Module: temporal checks on the timer bank, bound to the top module.
// Assumes: observes the end-count pulses, enables, select mask and request.
module ctb_checker #(
    parameter int NUM       = 4,
    parameter int PULSE_LEN = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NUM-1:0] evt,
    input logic [NUM-1:0] en,
    input logic [NUM-1:0] sel,
    input logic           rst_req
);
    logic [31:0] hi_cnt;

    // Count consecutive cycles of the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= 32'd0;
        else if (rst_req)
            hi_cnt <= hi_cnt + 32'd1;
        else
            hi_cnt <= 32'd0;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel == '0 && !rst_req));

    assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(|(evt & sel)));

    assert_req_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && hi_cnt != 32'd0) |-> (hi_cnt >= 32'(PULSE_LEN)));

    for (genvar i = 0; i < NUM; i++) begin : g_chk
        assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> !evt[i]);
        assert_pulse_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |-> $past(en[i]));
    end

endmodule

bind chain_timer_bank ctb_checker #(
    .NUM       (NUM),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (end_count_o),
    .en      (tmr_en),
    .sel     (wd_sel),
    .rst_req (rst_req_o)
);

// File: tb/chain_timer_bank_test.sv
// Bench: scoreboard for register reads plus cycle-exact pulse timing checks.
module chain_timer_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  end_count_o;
    logic        rst_req_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    chain_timer_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .end_count_o (end_count_o),
        .rst_req_o   (rst_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected word for the monitor.
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: the word is due one cycle after the strobe (R10).
    always @(posedge clk) begin
        if (bus_rd) begin
            #2;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read", 0, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    // Count cycles after the last write edge until the pulse on timer idx.
    task automatic wait_evt(input int idx, input int maxc, output int k);
        k = -1;
        for (int c = 1; c <= maxc; c++) begin
            @(posedge clk); #1;
            if (end_count_o[idx]) begin
                k = c;
                break;
            end
        end
    endtask

    // Watch that timer idx stays silent for n cycles.
    task automatic quiet(input int idx, input int n, input string tag);
        bit seen = 1'b0;
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #1;
            if (end_count_o[idx]) seen = 1'b1;
        end
        chk(!seen, tag, seen, 0);
    endtask

    task automatic kick();
        wr(8'h00, 32'h0000_0200);
        wr(8'h00, 32'h0000_0201);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk(rst_req_o === 1'b0, "R1 reset request low", rst_req_o, 0);
        rd(8'h00, 32'h0000_0200, "R1 ctrl0 reset");
        rd(8'h10, 32'h0000_0200, "R1 ctrl1 reset");
        rd(8'h20, 32'h0000_0201, "R1 ctrl2 reset");
        rd(8'h30, 32'h0000_0201, "R1 ctrl3 reset");
        rd(8'h40, 32'h0000_0000, "R1 select reset");

        // R2 field layout, read-only bit 1 and ignored upper half
        wr(8'h00, 32'hFFFF_3A5E);
        rd(8'h00, 32'h0000_3A5C, "R2 ctrl field readback");
        wr(8'h00, 32'h0000_0200);
        rd(8'h00, 32'h0000_0200, "R2 ctrl restore");

        // R7 high word captured on low read
        wr(8'h14, 32'h0000_0007);
        wr(8'h18, 32'h0000_0005);
        rd(8'h14, 32'h0000_0007, "R7 low word");
        wr(8'h18, 32'h0000_0009);
        rd(8'h18, 32'h0000_0005, "R7 captured high");
        rd(8'h14, 32'h0000_0007, "R7 low again");
        rd(8'h18, 32'h0000_0009, "R7 fresh high");

        // R3 one-shot, count 5, prescaler 2
        wr(8'h04, 32'd5);
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h0000_0201);
        wait_evt(0, 100, k);
        chk(k == 11, "R3 pulse cycle P=2", k, 11);
        @(posedge clk); #1;
        chk(end_count_o[0] === 1'b0, "R9 pulse one cycle", end_count_o[0], 0);
        rd(8'h04, 32'd0, "R3 count zero");
        rd(8'h00, 32'h0000_0201, "R3 active cleared");

        // R3 prescaler 3, count 4
        wr(8'h00, 32'h0000_0300);
        wr(8'h04, 32'd4);
        wr(8'h00, 32'h0000_0301);
        wait_evt(0, 100, k);
        chk(k == 13, "R3 pulse cycle P=3", k, 13);

        // R4 prescaler 0 and 1 act as 2
        wr(8'h00, 32'h0000_0000);
        wr(8'h04, 32'd3);
        wr(8'h00, 32'h0000_0001);
        wait_evt(0, 100, k);
        chk(k == 7, "R4 prescaler 0", k, 7);
        wr(8'h00, 32'h0000_0100);
        wr(8'h04, 32'd3);
        wr(8'h00, 32'h0000_0101);
        wait_evt(0, 100, k);
        chk(k == 7, "R4 prescaler 1", k, 7);

        // R5 zero count fires at once
        wr(8'h00, 32'h0000_0200);
        wr(8'h04, 32'd0);
        wr(8'h00, 32'h0000_0201);
        wait_evt(0, 20, k);
        chk(k == 1, "R5 immediate pulse", k, 1);

        // R9 disable mid-count stops the timer
        wr(8'h00, 32'h0000_0200);
        wr(8'h04, 32'd10);
        wr(8'h00, 32'h0000_0201);
        rd(8'h00, 32'h0000_0203, "R2 active while counting");
        wr(8'h00, 32'h0000_0200);
        quiet(0, 40, "R9 no pulse after disable");
        rd(8'h00, 32'h0000_0200, "R9 ctrl disabled");
        wr(8'h04, 32'd0);

        // R6 retrigger mode on timer 1, reload 4
        wr(8'h14, 32'd4);
        wr(8'h18, 32'd0);
        wr(8'h10, 32'h0000_025D);
        quiet(1, 30, "R6 enable alone does not start");
        rd(8'h10, 32'h0000_025D, "R6 idle until trigger");
        kick();
        wait_evt(1, 100, k);
        chk(k == 11, "R6 chained pulse cycle", k, 11);
        wr(8'h10, 32'h0000_023D);
        kick();
        quiet(1, 30, "R6 other trigger code ignored");

        // R8 watchdog on timer 1, reload 20
        wr(8'h14, 32'd20);
        wr(8'h10, 32'h0000_025D);
        wr(8'h40, 32'h0000_0002);
        rd(8'h40, 32'h0000_0002, "R8 select readback");
        begin
            bit raised = 1'b0;
            for (int r = 0; r < 5; r++) begin
                kick();
                for (int c = 0; c < 20; c++) begin
                    @(posedge clk); #1;
                    if (rst_req_o) raised = 1'b1;
                end
            end
            chk(!raised, "R8 timely kicks hold off request", raised, 0);
        end
        kick();
        k = -1;
        for (int c = 1; c <= 100; c++) begin
            @(posedge clk); #1;
            if (rst_req_o) begin k = c; break; end
        end
        chk(k == 44, "R8 request start cycle", k, 44);
        begin
            int len = 1;
            for (int c = 0; c < 40; c++) begin
                @(posedge clk); #1;
                if (rst_req_o) len++;
                else break;
            end
            chk(len == 16, "R8 request length", len, 16);
        end

        // R8 deselected timer is ignored
        wr(8'h40, 32'h0000_0000);
        kick();
        begin
            bit raised = 1'b0;
            for (int c = 0; c < 80; c++) begin
                @(posedge clk); #1;
                if (rst_req_o) raised = 1'b1;
            end
            chk(!raised, "R8 deselected no request", raised, 0);
        end

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
        finish_run();
    end

endmodule